// File: doc/BRIEF.md
# Posted Write Buffer with Byte Merge

This block holds CPU writes that are headed for a slower target bus, so that the CPU can move on before the target accepts them. Each slot holds one 32-bit data word and its own 32-bit address. A single command input picks one operation per clock. Two post commands take the low or the high half of the 64-bit host data bus, together with the host address. Bit 2 of the stored address is set by the command itself. A configuration post takes the high half but keeps the address exactly as supplied. A special-code post stores the host address lines as the data word.

After a word is posted, merge commands can rewrite its upper bytes. A merge copies the top three, top two or top one byte of a chosen data half into the most recently posted slot and leaves that slot's address alone. A 64-bit write is a post-low followed by a post-high. The drain side offers the oldest slot with a valid signal and removes it on a valid-and-ready handshake.

Top module: `post_merge_buf`

## Requirements
- R1: Command 4'h1 (post-low) pushes a slot with data = host_data[31:0] and address = host_addr with bit 2 cleared.
- R2: Command 4'h2 (post-high) pushes a slot with data = host_data[63:32] and address = host_addr with bit 2 set. A post-low followed by a post-high drains as two slots in that order.
- R3: Command 4'h3 (configuration post-high) pushes a slot with data = host_data[63:32] and address = host_addr unchanged, including a bit 2 of zero.
- R4: Command 4'h4 (special post) pushes a slot whose data and address both equal host_addr.
- R5: Merge commands rewrite only the most recently posted slot and never change its address. From the low half: 4'h5 replaces bytes 3..1, 4'h6 replaces bytes 3..2, 4'h7 replaces byte 3. From the high half: 4'h8, 4'h9 and 4'hA do the same. Byte k is bits [8k+7:8k] of the selected half.
- R6: A merge command while the buffer is empty is ignored: no slot is allocated and empty stays high.
- R7: drain_valid equals not-empty, and drain_addr/drain_data show the oldest slot. A slot is removed on a clock edge where drain_valid and drain_ready are both high. While it waits, the address shown does not change.
- R8: The depth is the parameter DEPTH (default 4). full is high when DEPTH slots are held and empty is high when none are held. The two are never high together.
- R9: A post command while full is dropped, and overflow is high for exactly the one cycle after it. overflow is never high otherwise.
- R10: After reset the buffer is empty, full is low, overflow is low and drain_valid is low. Command 4'h0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | Operation code, one per cycle |
| host_addr | input | 32 | Host address lines |
| host_data | input | 64 | Host data bus |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |
| overflow | output | 1 | One-cycle pulse after a dropped post |
| drain_valid | output | 1 | Oldest slot is available |
| drain_ready | input | 1 | Target accepts the oldest slot |
| drain_addr | output | 32 | Address of oldest slot |
| drain_data | output | 32 | Data of oldest slot |

## Verification
The hardest case to reach is a merge that must land on the newest slot while older slots are still waiting, because the drain port only shows the oldest slot. The stimulus posts two words, merges with the drain held off, and then pops both. The first word must come out untouched and the second must show the merged bytes. A merge chain that alternates between data halves and byte counts checks each byte mask. Filling the buffer and then posting once more gives the dropped-write pulse.

// File: rtl/post_merge_buf.sv
module post_merge_buf #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd,
  input  logic [AW-1:0]   host_addr,
  input  logic [2*DW-1:0] host_data,
  output logic            full,
  output logic            empty,
  output logic            overflow,
  output logic            drain_valid,
  input  logic            drain_ready,
  output logic [AW-1:0]   drain_addr,
  output logic [DW-1:0]   drain_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NB = DW / 8;

  localparam logic [3:0] C_POST_LO = 4'h1, C_POST_HI = 4'h2, C_POST_CFG = 4'h3,
                         C_POST_SPC = 4'h4;

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] wptr, rptr, last;
  logic [CW-1:0] count;

  logic          is_post, push, pop, is_merge, merge_hi;
  logic [1:0]    merge_n;
  logic [AW-1:0] new_addr;
  logic [DW-1:0] new_data, merge_src, merged;

  assign full        = (count == CW'(DEPTH));
  assign empty       = (count == '0);
  assign drain_valid = !empty;
  assign drain_addr  = addr_mem[rptr];
  assign drain_data  = data_mem[rptr];
  assign last        = (wptr == '0) ? PW'(DEPTH - 1) : wptr - 1'b1;

  assign is_post  = (cmd >= C_POST_LO) && (cmd <= C_POST_SPC);
  assign push     = is_post && !full;
  assign pop      = drain_valid && drain_ready;
  assign is_merge = (cmd >= 4'h5) && (cmd <= 4'hA);
  assign merge_hi = (cmd >= 4'h8);

  always_comb begin
    new_addr = host_addr;
    new_data = host_data[DW-1:0];
    case (cmd)
      C_POST_LO:  new_addr[2] = 1'b0;
      C_POST_HI:  begin new_addr[2] = 1'b1; new_data = host_data[2*DW-1:DW]; end
      C_POST_CFG: new_data = host_data[2*DW-1:DW];
      C_POST_SPC: new_data = DW'(host_addr);
      default:    ;
    endcase
  end

  always_comb begin
    case (cmd)
      4'h5, 4'h8: merge_n = 2'd3;
      4'h6, 4'h9: merge_n = 2'd2;
      default:    merge_n = 2'd1;
    endcase
    merge_src = merge_hi ? host_data[2*DW-1:DW] : host_data[DW-1:0];
    merged    = data_mem[last];
    for (int b = 0; b < NB; b++)
      if (b >= NB - int'(merge_n)) merged[8*b +: 8] = merge_src[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wptr] <= new_addr;
      data_mem[wptr] <= new_data;
    end else if (is_merge && !empty) begin
      data_mem[last] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= is_post && full;
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

module post_merge_buf_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cmd,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          drain_valid,
  input logic          drain_ready,
  input logic [AW-1:0] drain_addr,
  input logic [DW-1:0] drain_data
);
  logic posting, merging;
  assign posting = (cmd >= 4'h1) && (cmd <= 4'h4);
  assign merging = (cmd >= 4'h5) && (cmd <= 4'hA);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_valid_tracks_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid == !empty);

  assert_overflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(full && posting));

  assert_merge_empty_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && merging) |=> empty);

  assert_wait_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=> $stable(drain_addr));

  assert_overflow_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(full && posting)) |=> !overflow);
endmodule

bind post_merge_buf post_merge_buf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .full(full), .empty(empty),
  .overflow(overflow), .drain_valid(drain_valid), .drain_ready(drain_ready),
  .drain_addr(drain_addr), .drain_data(drain_data));

// File: tb/post_merge_buf_bench.sv
module post_merge_buf_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  cmd = 4'h0;
  logic [31:0] host_addr = '0;
  logic [63:0] host_data = '0;
  logic        drain_ready = 0;
  logic        full, empty, overflow, drain_valid;
  logic [31:0] drain_addr, drain_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  post_merge_buf u_post_merge_buf (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .host_addr(host_addr),
    .host_data(host_data), .full(full), .empty(empty), .overflow(overflow),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_addr(drain_addr), .drain_data(drain_data));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(logic [3:0] c, logic [31:0] a, logic [63:0] d);
    cmd = c; host_addr = a; host_data = d;
    @(posedge clk); #1;
    cmd = 4'h0;
  endtask

  task automatic pop_expect(string req, logic [31:0] ea, logic [31:0] ed);
    chk({req, " valid"}, drain_valid, 1);
    chk({req, " addr"}, drain_addr, ea);
    chk({req, " data"}, drain_data, ed);
    drain_ready = 1;
    @(posedge clk); #1;
    drain_ready = 0;
  endtask

  task automatic t_reset;
    chk("R10 empty", empty, 1);
    chk("R10 full", full, 0);
    chk("R10 overflow", overflow, 0);
    chk("R10 valid", drain_valid, 0);
    issue(4'h0, 32'h1234_5678, 64'h1);
    chk("R10 nop empty", empty, 1);
  endtask

  task automatic t_post_lo;
    issue(4'h1, 32'h1000_0004, 64'hDEAD_BEEF_CAFE_F00D);
    pop_expect("R1", 32'h1000_0000, 32'hCAFE_F00D);
  endtask

  task automatic t_post_hi_qword;
    issue(4'h2, 32'h2000_0000, 64'h1111_2222_3333_4444);
    pop_expect("R2 hi", 32'h2000_0004, 32'h1111_2222);
    issue(4'h1, 32'h3000_0008, 64'hAAAA_BBBB_CCCC_DDDD);
    issue(4'h2, 32'h3000_0008, 64'hAAAA_BBBB_CCCC_DDDD);
    pop_expect("R2 qword first", 32'h3000_0008, 32'hCCCC_DDDD);
    pop_expect("R2 qword second", 32'h3000_000C, 32'hAAAA_BBBB);
  endtask

  task automatic t_cfg_special;
    issue(4'h3, 32'h8000_0010, 64'h5566_7788_99AA_BBCC);
    pop_expect("R3", 32'h8000_0010, 32'h5566_7788);
    issue(4'h4, 32'h0000_0002, 64'hFFFF_FFFF_FFFF_FFFF);
    pop_expect("R4", 32'h0000_0002, 32'h0000_0002);
  endtask

  task automatic t_merge;
    issue(4'h1, 32'h0000_0100, 64'h0000_0000_1122_3344);
    issue(4'h5, 32'hFFFF_FFFF, 64'h0000_0000_AABB_CCDD);
    issue(4'h7, 32'hFFFF_FFFF, 64'h0000_0000_EE00_0000);
    issue(4'h9, 32'h0, 64'h5566_7788_0000_0000);
    issue(4'hA, 32'h0, 64'h99FF_FFFF_0000_0000);
    pop_expect("R5 chain", 32'h0000_0100, 32'h9966_CC44);
    issue(4'h1, 32'h0000_0200, 64'h0000_0000_0102_0304);
    issue(4'h2, 32'h0000_0200, 64'h0506_0708_0000_0000);
    issue(4'h6, 32'h0, 64'h0000_0000_F1F2_F3F4);
    pop_expect("R5 older untouched", 32'h0000_0200, 32'h0102_0304);
    pop_expect("R5 newest merged", 32'h0000_0204, 32'hF1F2_0708);
    issue(4'h2, 32'h0000_0300, 64'h0A0B_0C0D_0000_0000);
    issue(4'h8, 32'h0, 64'hE1E2_E3E4_0000_0000);
    pop_expect("R5 hi3", 32'h0000_0304, 32'hE1E2_E30D);
  endtask

  task automatic t_merge_empty;
    chk("R6 pre empty", empty, 1);
    issue(4'h5, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 empty after merge", empty, 1);
    chk("R6 no valid", drain_valid, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4; i++) begin
      chk("R8 not full while filling", full, 0);
      issue(4'h1, 32'h4000_0000 + 32'(i * 16), 64'(32'hA000_0000 + i));
    end
    chk("R8 full", full, 1);
    chk("R8 not empty", empty, 0);
    chk("R9 no early overflow", overflow, 0);
    issue(4'h2, 32'h5000_0000, 64'hBAD0_BAD0_BAD0_BAD0);
    chk("R9 overflow pulse", overflow, 1);
    @(posedge clk); #1;
    chk("R9 overflow one cycle", overflow, 0);
    @(posedge clk); #1;
    chk("R7 stall keeps oldest", drain_addr, 32'h4000_0000);
    for (int i = 0; i < 4; i++)
      pop_expect("R7/R9 order", 32'h4000_0000 + 32'(i * 16), 32'hA000_0000 + 32'(i));
    chk("R8 empty after drain", empty, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_post_lo();
    t_post_hi_qword();
    t_cfg_special();
    t_merge();
    t_merge_empty();
    t_overflow();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule